// File: doc/BRIEF.md
# Mode-Switched Shared Microcode RAM

This block is a single-clock static RAM of 1536 32-bit words (6 KB) with three ways in. In normal mode a host bus reaches the array through a simple request and acknowledge handshake, and the RAM serves as general-purpose data storage. When either of two coprocessor engines raises its emulation line, the host loses the array. The two engines then fetch microcode words through their own read ports. Both engines may read in the same cycle without stalling each other.

A small register space on the host bus holds a stop bit and the controls for a signature scanner. The stop bit makes the block refuse host array traffic, which saves power. The scanner walks every word of the array and folds each word into a 32-bit multiple-input shift register. The host can then read the result and compare it with a known value to detect corruption. The scanner only uses cycles in which neither the host nor an engine touches the array.

Top module: `mport_ram`

## Requirements
- R1: After reset, `h_ack`, `h_err`, `e0_vld` and `e1_vld` are 0. The control register reads 0 and the signature register reads 0.
- R2: The block samples a host request on a rising edge when it is idle, with `h_req` high. After the next rising edge, exactly one of `h_ack` or `h_err` is high for one cycle, and `h_rdata` is valid in that same cycle. Neither `h_ack` nor `h_err` is high after the sampling edge itself.
- R3: A host address with its top bit set selects the registers, and bit 0 picks between them. Index 0 is control: bit 0 is the stop bit (read/write), bit 1 starts a signature pass when written with 1 (it reads 0), bit 2 is pass-done and bit 3 is pass-busy. Index 1 is the signature and is read-only. Register accesses are always acknowledged with `h_ack`.
- R4: In normal mode with stop clear, a host write stores `h_wdata` at the word index given by the low address bits. A later host read returns that word.
- R5: A host array access whose word index is not below WORDS is answered with `h_err`. It returns read data 0 and stores nothing.
- R6: While `e0_emu` or `e1_emu` is high, every host array access is answered with `h_err` and read data 0. Writes are dropped. Register accesses are still acknowledged.
- R7: While emulation mode is active, `eN_rd` with `eN_addr` makes `eN_vld` high on the next cycle, with the stored word on `eN_data`. Both ports may read in the same cycle. Outside emulation mode `eN_vld` stays 0.
- R8: While the stop bit is set, host array accesses are answered with `h_err`. Registers remain accessible, and the engine ports work as in R7.
- R9: A signature pass seeds the signature with all ones. For each word w, at indices 0 to WORDS-1 in order, it computes sig = {sig[30:0],0} ^ (sig[31] ? 32'h04C11DB7 : 0) ^ w. At the end of the pass it sets done and clears busy.
- R10: Starting a pass clears done, sets busy and restarts the walk at index 0. The walk pauses in any cycle in which a host array access or an engine read uses the array. Pauses do not change the final signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| h_req | input | 1 | host request, held until acknowledged |
| h_we | input | 1 | host write (1) or read (0) |
| h_addr | input | AW+1 | top bit selects registers, low bits the word index |
| h_wdata | input | 32 | host write data |
| h_ack | output | 1 | host access completed |
| h_err | output | 1 | host access refused |
| h_rdata | output | 32 | host read data |
| e0_emu | input | 1 | engine 0 emulation mode |
| e0_rd | input | 1 | engine 0 read request |
| e0_addr | input | AW | engine 0 word index |
| e0_vld | output | 1 | engine 0 data valid |
| e0_data | output | 32 | engine 0 read data |
| e1_emu | input | 1 | engine 1 emulation mode |
| e1_rd | input | 1 | engine 1 read request |
| e1_addr | input | AW | engine 1 word index |
| e1_vld | output | 1 | engine 1 data valid |
| e1_data | output | 32 | engine 1 read data |

## Verification
The bench uses a 12-word array, so the upper four indices are out of range. It fills every word and reads it back, then repeats that sweep from both engine ports at once with mirrored addresses. A design that shared one read path between the engines would return the wrong word on one port. Host writes issued during emulation are checked by reading the word back once emulation ends. Out-of-range and stopped accesses must give an error rather than an acknowledge. A block that still serviced them would corrupt the array or leave `h_ack` high. Signature passes are compared with a value the bench computes itself. One pass runs with the host reading the array alongside it, and another runs under a continuous engine read stream that must hold it at busy. A walker that skipped or repeated words on contention would give a different signature.

// File: rtl/mport_ram.sv
module mport_ram #(
  parameter int WORDS = 1536,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_req,
  input  logic          h_we,
  input  logic [AW:0]   h_addr,
  input  logic [31:0]   h_wdata,
  output logic          h_ack,
  output logic          h_err,
  output logic [31:0]   h_rdata,
  input  logic          e0_emu,
  input  logic          e0_rd,
  input  logic [AW-1:0] e0_addr,
  output logic          e0_vld,
  output logic [31:0]   e0_data,
  input  logic          e1_emu,
  input  logic          e1_rd,
  input  logic [AW-1:0] e1_addr,
  output logic          e1_vld,
  output logic [31:0]   e1_data
);
  localparam logic [31:0]   POLY  = 32'h04C11DB7;
  localparam logic [AW-1:0] LASTW = AW'(WORDS - 1);

  logic [31:0] mem [WORDS];

  logic          pend, p_we;
  logic [AW:0]   p_addr;
  logic [31:0]   p_wdata;
  logic          stop, sig_busy, sig_done;
  logic [31:0]   sig;
  logic [AW-1:0] waddr;

  wire          emu_mode = e0_emu | e1_emu;
  wire          p_reg    = p_addr[AW];
  wire [AW-1:0] p_idx    = p_addr[AW-1:0];
  wire          p_inr    = p_idx <= LASTW;
  wire          arr_ok   = pend & ~p_reg & p_inr & ~emu_mode & ~stop;
  wire          arr_wr   = arr_ok & p_we;
  wire          e0_act   = emu_mode & e0_rd;
  wire          e1_act   = emu_mode & e1_rd;
  wire          arr_busy = arr_ok | e0_act | e1_act;
  wire          reg_wr   = pend & p_reg & p_we & ~p_idx[0];
  wire          sig_start = reg_wr & p_wdata[1];
  wire          step     = sig_busy & ~arr_busy & ~sig_start;
  wire [31:0]   ctrl_rd  = {28'd0, sig_busy, sig_done, 1'b0, stop};
  wire [31:0]   wword    = mem[waddr];
  wire [31:0]   sig_nxt  = {sig[30:0], 1'b0} ^ (sig[31] ? POLY : 32'd0) ^ wword;

  // host port: sample, then complete one edge later
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; p_we <= 1'b0; p_addr <= '0; p_wdata <= '0;
      h_ack <= 1'b0; h_err <= 1'b0; h_rdata <= '0;
    end else begin
      h_ack <= 1'b0;
      h_err <= 1'b0;
      if (pend) begin
        pend <= 1'b0;
        if (p_reg) begin
          h_ack   <= 1'b1;
          h_rdata <= p_we ? 32'd0 : (p_idx[0] ? sig : ctrl_rd);
        end else if (arr_ok) begin
          h_ack   <= 1'b1;
          h_rdata <= p_we ? 32'd0 : mem[p_idx];
        end else begin
          h_err   <= 1'b1;
          h_rdata <= 32'd0;
        end
      end else if (h_req && !h_ack && !h_err) begin
        pend <= 1'b1; p_we <= h_we; p_addr <= h_addr; p_wdata <= h_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (arr_wr) mem[p_idx] <= p_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stop <= 1'b0;
    else if (reg_wr) stop <= p_wdata[0];
  end

  // signature walker
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig <= '0; waddr <= '0; sig_busy <= 1'b0; sig_done <= 1'b0;
    end else if (sig_start) begin
      sig <= '1; waddr <= '0; sig_busy <= 1'b1; sig_done <= 1'b0;
    end else if (step) begin
      sig <= sig_nxt;
      if (waddr == LASTW) begin
        sig_busy <= 1'b0;
        sig_done <= 1'b1;
      end else begin
        waddr <= waddr + 1'b1;
      end
    end
  end

  // engine read ports
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e0_vld <= 1'b0; e0_data <= '0; e1_vld <= 1'b0; e1_data <= '0;
    end else begin
      e0_vld <= e0_act;
      e1_vld <= e1_act;
      if (e0_act) e0_data <= (e0_addr <= LASTW) ? mem[e0_addr] : 32'd0;
      if (e1_act) e1_data <= (e1_addr <= LASTW) ? mem[e1_addr] : 32'd0;
    end
  end

  AST_ACK_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n) !(h_ack && h_err)); // R2
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (h_ack || h_err) |=> !(h_ack || h_err)); // R2
  AST_PEND_DONE: assert property (@(posedge clk) disable iff (!rst_n) pend |=> (h_ack || h_err)); // R2
  AST_EMU_REFUSE: assert property (@(posedge clk) disable iff (!rst_n) (pend && !p_reg && emu_mode) |=> (h_err && h_rdata == 32'd0)); // R6
  AST_ENG0_VLD: assert property (@(posedge clk) disable iff (!rst_n) (e0_rd && emu_mode) |=> e0_vld); // R7
  AST_ENG1_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !(e1_rd && emu_mode) |=> !e1_vld); // R7
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) !(sig_done && sig_busy)); // R9
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n) sig_start |=> (sig_busy && !sig_done && waddr == '0)); // R10
  AST_WALK_PAUSE: assert property (@(posedge clk) disable iff (!rst_n) (sig_busy && arr_busy && !sig_start) |=> $stable(waddr) && $stable(sig)); // R10
endmodule

// File: tb/mport_ram_tb.sv
module mport_ram_tb;
  localparam int WORDS = 12;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic h_req = 0, h_we = 0;
  logic [AW:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic h_ack, h_err;
  logic [31:0] h_rdata;
  logic e0_emu = 0, e0_rd = 0, e1_emu = 0, e1_rd = 0;
  logic [AW-1:0] e0_addr = '0, e1_addr = '0;
  logic e0_vld, e1_vld;
  logic [31:0] e0_data, e1_data;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] model [WORDS];
  logic r_ack, r_err, early;
  logic [31:0] r_dat, expsig;

  mport_ram #(.WORDS(WORDS), .AW(AW)) u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  task automatic host(input logic we, input logic [AW:0] a, input logic [31:0] d);
    @(negedge clk);
    h_req = 1; h_we = we; h_addr = a; h_wdata = d;
    @(posedge clk); #1;
    early = h_ack | h_err;
    @(posedge clk); #1;
    r_ack = h_ack; r_err = h_err; r_dat = h_rdata;
    @(negedge clk);
    h_req = 0;
  endtask

  function automatic logic [31:0] calc_sig();
    logic [31:0] s = '1;
    for (int i = 0; i < WORDS; i++)
      s = {s[30:0], 1'b0} ^ (s[31] ? 32'h04C11DB7 : 32'd0) ^ model[i];
    return s;
  endfunction

  localparam logic [AW:0] CTRL = {1'b1, 4'd0};
  localparam logic [AW:0] SIGR = {1'b1, 4'd1};

  task automatic wait_sig();
    for (int k = 0; k < 60; k++) begin
      host(0, CTRL, 0);
      if (r_dat[3] == 1'b0) break;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk(!h_ack && !h_err && !e0_vld && !e1_vld, "R1 outputs idle", {h_ack, h_err, e0_vld, e1_vld}, 0);
    host(0, CTRL, 0);
    chk(r_ack && r_dat == 0, "R1 control reset", r_dat, 0);
    host(0, SIGR, 0);
    chk(r_ack && r_dat == 0, "R1 signature reset", r_dat, 0);

    for (int i = 0; i < WORDS; i++) begin
      model[i] = 32'h5A3C0F00 ^ (32'(i) * 32'h01030507);
      host(1, {1'b0, 4'(i)}, model[i]);
      chk(r_ack && !r_err && !early, "R2 write handshake", {early, r_ack, r_err}, 3'b010);
    end
    for (int i = 0; i < WORDS; i++) begin
      host(0, {1'b0, 4'(i)}, 0);
      chk(r_ack && r_dat == model[i], "R4 readback", r_dat, model[i]);
    end
    for (int i = WORDS; i < 16; i++) begin
      host(1, {1'b0, 4'(i)}, 32'hDEAD0000);
      chk(r_err && !r_ack, "R5 out of range write", {r_ack, r_err}, 2'b01);
      host(0, {1'b0, 4'(i)}, 0);
      chk(r_err && r_dat == 0, "R5 out of range read", r_dat, 0);
    end
    host(1, SIGR, 32'h12345678);
    host(0, SIGR, 0);
    chk(r_ack && r_dat == 0, "R3 signature read-only", r_dat, 0);

    expsig = calc_sig();
    host(1, CTRL, 32'h2);
    wait_sig();
    chk(r_dat == 32'h4, "R9 done flag", r_dat, 32'h4);
    host(0, SIGR, 0);
    chk(r_dat == expsig, "R9 signature", r_dat, expsig);

    host(1, CTRL, 32'h2);
    host(0, CTRL, 0);
    chk(r_dat == 32'h8, "R10 restart clears done", r_dat, 32'h8);
    for (int i = 0; i < 4; i++) host(0, {1'b0, 4'(i)}, 0);
    wait_sig();
    host(0, SIGR, 0);
    chk(r_dat == expsig, "R10 signature with host contention", r_dat, expsig);

    host(1, CTRL, 32'h1);
    host(0, CTRL, 0);
    chk(r_ack && r_dat == 32'h5, "R8 stop readable", r_dat, 32'h5);
    host(1, {1'b0, 4'd3}, 32'hBAD0BAD0);
    chk(r_err && !r_ack, "R8 stopped write refused", {r_ack, r_err}, 2'b01);
    host(0, {1'b0, 4'd3}, 0);
    chk(r_err && r_dat == 0, "R8 stopped read refused", r_dat, 0);
    @(negedge clk) e1_emu = 1; e0_rd = 1; e0_addr = 4'd3;
    @(posedge clk); #1;
    chk(e0_vld && e0_data == model[3], "R8 engine unaffected by stop", e0_data, model[3]);
    @(negedge clk) e0_rd = 0; e1_emu = 0;
    host(1, CTRL, 32'h0);

    @(negedge clk) e0_rd = 1; e0_addr = 4'd1;
    @(posedge clk); #1;
    chk(!e0_vld, "R7 no read outside emulation", e0_vld, 0);
    @(negedge clk) e0_rd = 0; e0_emu = 1;

    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      e0_rd = 1; e1_rd = 1; e0_addr = 4'(i); e1_addr = 4'(WORDS - 1 - i);
      @(posedge clk); #1;
      chk(e0_vld && e0_data == model[i], "R7 engine0 read", e0_data, model[i]);
      chk(e1_vld && e1_data == model[WORDS-1-i], "R7 engine1 read", e1_data, model[WORDS-1-i]);
    end
    @(negedge clk) e0_rd = 0; e1_rd = 0;

    host(1, {1'b0, 4'd5}, 32'hFFFF0000);
    chk(r_err && !r_ack, "R6 emulation write refused", {r_ack, r_err}, 2'b01);
    host(0, {1'b0, 4'd5}, 0);
    chk(r_err && r_dat == 0, "R6 emulation read refused", r_dat, 0);
    host(0, CTRL, 0);
    chk(r_ack, "R6 registers open in emulation", r_ack, 1);

    host(1, CTRL, 32'h2);
    @(negedge clk) e0_rd = 1; e0_addr = 4'd2;
    repeat (30) @(posedge clk);
    @(negedge clk);
    host(0, CTRL, 0);
    chk(r_dat == 32'h8, "R10 walker paused by engine", r_dat, 32'h8);
    @(negedge clk) e0_rd = 0;
    wait_sig();
    host(0, SIGR, 0);
    chk(r_dat == expsig, "R10 signature after pause", r_dat, expsig);

    @(negedge clk) e0_emu = 0;
    host(0, {1'b0, 4'd5}, 0);
    chk(r_ack && r_dat == model[5], "R6 dropped write left word intact", r_dat, model[5]);

    finish_run();
  end
endmodule